// File: doc/BRIEF.md
# External Sync Clock Qualifier and Source Selector

This block decides whether a switching regulator's clock follows an external SYNC input or stays on its internal 3 MHz oscillator. The SYNC input is first brought through a two-flop synchronizer into a faster reference clock domain. There the block counts reference cycles between consecutive SYNC rising edges. Each measured period is compared against a window of cycle counts, and the 2-bit multiplier code selects which window applies. The codes 00, 01, 10 and 11 correspond to dividers 1, 2, 3 and 4, and to typical SYNC rates of 3.00, 1.50, 1.00 and 0.75 MHz.

Two consecutive in-window periods qualify SYNC. The block then raises its status flag and, unless sync is forced off, selects the external clock. The block falls back to the internal oscillator at once in any of these cases:
- a single period falls outside the window;
- SYNC goes quiet for too long;
- the multiplier code or the enable bit changes.

Sync is forced off whenever the mode-control field is 00 and the VSEL pin is low, whatever the enable bit says.

Top module: `sync_clk_sel`

## Requirements
- R1: While reset is high and on the first cycle after it, `sync_ok` and `ext_sel` are 0, so the internal oscillator is selected.
- R2: With the default 48 MHz reference, a SYNC period of N reference cycles is in window when it lies inside the inclusive bounds for the current `mult_sel` code:
  - code 00: 12..27
  - code 01: 24..54
  - code 10: 36..80
  - code 11: 48..107
- R3: After a restart, `sync_ok` rises only after two consecutive in-window periods have been measured, that is, on the third SYNC rising edge. It then stays high while periods remain in window.
- R4: A single out-of-window period clears `sync_ok` and `ext_sel` within 5 reference cycles of the SYNC rising edge that closes that period.
- R5: If no SYNC rising edge arrives within twice the current upper bound of R2 (counted in reference cycles from the last edge), `sync_ok` clears.
- R6: A change of `mult_sel` or of `sync_en` clears `sync_ok` and restarts qualification. While `sync_en` is 0, `sync_ok` stays 0 even with a valid SYNC.
- R7: `ext_sel` equals, one cycle later, `sync_ok` AND `sync_en` AND NOT forced-off. Forced-off is `mode_ctl == 2'b00` with `vsel_pin` low. Forced-off leaves `sync_ok` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock used for period measurement (48 MHz by default) |
| rst | input | 1 | Synchronous active-high reset |
| sync_en | input | 1 | Enables use of the external SYNC clock |
| mult_sel | input | 2 | Multiplier code; picks the valid SYNC window |
| mode_ctl | input | 2 | Mode-control field; value 00 together with a low `vsel_pin` forces sync off |
| vsel_pin | input | 1 | Voltage-select pin level |
| sync_in | input | 1 | Asynchronous external SYNC clock |
| ext_sel | output | 1 | 1 selects the external SYNC clock, 0 the internal oscillator |
| sync_ok | output | 1 | SYNC is qualified as in-window |

## Verification
The bench builds the block with its default parameters: a 48 MHz reference, a two-stage synchronizer and two qualifying periods. These defaults put every window bound within a few dozen reference cycles, so both edges of all four windows can be driven exactly, one cycle inside and one cycle outside. The timeout is short enough to exercise in the same run. The short qualification depth also lets the bench count SYNC edges directly and check the qualification step, the single-bad-period drop, the timeout and the forced-off selection one event at a time.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;

  // upper limit of the SYNC window in kHz for a multiplier code
  function automatic int win_fmax_khz(input int code);
    case (code)
      0:       return 4000;
      1:       return 2000;
      2:       return 1330;
      default: return 1000;
    endcase
  endfunction

  // lower limit of the SYNC window in kHz for a multiplier code
  function automatic int win_fmin_khz(input int code);
    case (code)
      0:       return 1800;
      1:       return 900;
      2:       return 600;
      default: return 450;
    endcase
  endfunction

  // shortest accepted period in reference cycles (floor keeps fmax inside)
  function automatic int cyc_lo(input int ref_khz, input int code);
    return ref_khz / win_fmax_khz(code);
  endfunction

  // longest accepted period in reference cycles (ceil keeps fmin inside)
  function automatic int cyc_hi(input int ref_khz, input int code);
    return (ref_khz + win_fmin_khz(code) - 1) / win_fmin_khz(code);
  endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  assign rise_o = sh[STAGES-1] & ~sh[STAGES];

  a_r3_single_edge_pulse: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sync_period_meter.sv
module sync_period_meter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          rise,
  input  logic [CW-1:0] to_lim,
  output logic          meas_vld,
  output logic [CW-1:0] period,
  output logic          timeout
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt;
  logic          armed;
  logic [CW:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= CW'(1);
      armed    <= 1'b0;
      meas_vld <= 1'b0;
      period   <= '0;
      timeout  <= 1'b0;
    end else begin
      meas_vld <= 1'b0;
      timeout  <= 1'b0;
      if (rise) begin
        cnt <= CW'(1);
        if (armed && !restart) begin
          meas_vld <= 1'b1;
          period   <= cnt;
        end
        armed <= !restart;
      end else begin
        if (restart) armed <= 1'b0;
        if (cnt != CMAX) cnt <= cnt + 1'b1;
        if (cnt_nx == {1'b0, to_lim}) timeout <= 1'b1;
      end
    end
  end

  a_r2_period_nonzero: assert property (@(posedge clk) disable iff (rst)
    meas_vld |-> (period != '0));
  a_r5_timeout_single: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);
endmodule

// File: rtl/sync_qualifier.sv
module sync_qualifier #(
  parameter int CW   = 8,
  parameter int QUAL = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          timeout,
  input  logic          meas_vld,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic          ok
);
  localparam int QW = $clog2(QUAL + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL);

  logic [QW-1:0] good;
  logic          in_win;

  assign in_win = (period >= lo) && (period <= hi);

  always_ff @(posedge clk) begin
    if (rst || restart || timeout) begin
      good <= '0;
    end else if (meas_vld) begin
      if (!in_win)           good <= '0;
      else if (good != QMAX) good <= good + 1'b1;
    end
  end

  assign ok = (good == QMAX);

  a_r4_bad_period_clears: assert property (@(posedge clk) disable iff (rst)
    (meas_vld && !in_win) |=> !ok);
  a_r3_rise_needs_good: assert property (@(posedge clk) disable iff (rst)
    $rose(ok) |-> ($past(meas_vld) && $past(in_win)));
  a_r5_timeout_clears: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !ok);
  a_r6_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> !ok);
endmodule

// File: rtl/sync_clk_sel.sv
module sync_clk_sel #(
  parameter int REF_KHZ   = 48000,
  parameter int SYNC_STG  = 2,
  parameter int QUAL      = 2,
  parameter int NCODE     = 4
) (
  input  logic       clk_ref,
  input  logic       rst,
  input  logic       sync_en,
  input  logic [1:0] mult_sel,
  input  logic [1:0] mode_ctl,
  input  logic       vsel_pin,
  input  logic       sync_in,
  output logic       ext_sel,
  output logic       sync_ok
);
  import sync_sel_pkg::*;

  localparam int CW = $clog2(2 * cyc_hi(REF_KHZ, NCODE - 1) + 2);

  logic [CW-1:0] lo_tab [NCODE];
  logic [CW-1:0] hi_tab [NCODE];
  logic [CW-1:0] to_tab [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tab
    assign lo_tab[g] = CW'(cyc_lo(REF_KHZ, g));
    assign hi_tab[g] = CW'(cyc_hi(REF_KHZ, g));
    assign to_tab[g] = CW'(2 * cyc_hi(REF_KHZ, g));
  end

  logic [1:0]    mult_q;
  logic          en_q;
  logic          restart;
  logic          rise;
  logic          meas_vld;
  logic          timeout;
  logic [CW-1:0] period;
  logic          qual_ok;
  logic          forced_off;

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      mult_q <= '0;
      en_q   <= 1'b0;
    end else begin
      mult_q <= mult_sel;
      en_q   <= sync_en;
    end
  end

  assign restart    = (mult_sel != mult_q) || (sync_en != en_q) || !sync_en;
  assign forced_off = (mode_ctl == 2'b00) && !vsel_pin;

  sync_edge_det #(.STAGES(SYNC_STG)) u_edge (
    .clk(clk_ref), .rst(rst), .din(sync_in), .rise_o(rise)
  );

  sync_period_meter #(.CW(CW)) u_meter (
    .clk(clk_ref), .rst(rst), .restart(restart), .rise(rise),
    .to_lim(to_tab[mult_sel]), .meas_vld(meas_vld), .period(period),
    .timeout(timeout)
  );

  sync_qualifier #(.CW(CW), .QUAL(QUAL)) u_qual (
    .clk(clk_ref), .rst(rst), .restart(restart), .timeout(timeout),
    .meas_vld(meas_vld), .period(period), .lo(lo_tab[mult_sel]),
    .hi(hi_tab[mult_sel]), .ok(qual_ok)
  );

  always_ff @(posedge clk_ref) begin
    if (rst) ext_sel <= 1'b0;
    else     ext_sel <= qual_ok && sync_en && !forced_off;
  end

  assign sync_ok = qual_ok;

  a_r7_ext_needs_ok: assert property (@(posedge clk_ref) disable iff (rst)
    ext_sel |-> $past(sync_ok));
  a_r7_ext_not_forced: assert property (@(posedge clk_ref) disable iff (rst)
    ext_sel |-> !$past((mode_ctl == 2'b00) && !vsel_pin));
  a_r6_code_change_clears: assert property (@(posedge clk_ref) disable iff (rst)
    (mult_sel != $past(mult_sel)) |=> !sync_ok);
  a_r6_disabled_no_ok: assert property (@(posedge clk_ref) disable iff (rst)
    !sync_en |=> !sync_ok);
endmodule

// File: tb/sim_sync_clk_sel.sv
module sim_sync_clk_sel;
  localparam int TCLK = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_en = 1'b0;
  logic [1:0] mult_sel = 2'b00;
  logic [1:0] mode_ctl = 2'b01;
  logic       vsel_pin = 1'b0;
  logic       sync_in = 1'b0;
  logic       ext_sel;
  logic       sync_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  sync_clk_sel u0 (
    .clk_ref(clk), .rst(rst), .sync_en(sync_en), .mult_sel(mult_sel),
    .mode_ctl(mode_ctl), .vsel_pin(vsel_pin), .sync_in(sync_in),
    .ext_sel(ext_sel), .sync_ok(sync_ok)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int per, input int n);
    for (int i = 0; i < n; i++) begin
      sync_in = 1'b1;
      wait_cyc(per / 2);
      sync_in = 1'b0;
      wait_cyc(per - per / 2);
    end
  endtask

  task automatic restart_with(input logic [1:0] code);
    sync_en = 1'b0;
    mult_sel = code;
    wait_cyc(3);
    sync_en = 1'b1;
    wait_cyc(2);
  endtask

  task automatic t_reset;
    wait_cyc(1);
    chk("R1 sync_ok in reset", sync_ok, 1'b0);
    chk("R1 ext_sel in reset", ext_sel, 1'b0);
    rst = 1'b0;
    wait_cyc(1);
    chk("R1 sync_ok after reset", sync_ok, 1'b0);
    chk("R1 ext_sel after reset", ext_sel, 1'b0);
  endtask

  task automatic t_window(input logic [1:0] code, input int per, input logic exp);
    restart_with(code);
    pulses(per, 5);
    chk($sformatf("R2 code %0d period %0d sync_ok", code, per), sync_ok, exp);
    chk($sformatf("R2 code %0d period %0d ext_sel", code, per), ext_sel, exp);
  endtask

  task automatic t_qualify;
    restart_with(2'b00);
    pulses(16, 2);
    chk("R3 one period not enough", sync_ok, 1'b0);
    pulses(16, 1);
    chk("R3 two periods qualify", sync_ok, 1'b1);
    pulses(16, 3);
    chk("R3 stays qualified", sync_ok, 1'b1);
  endtask

  task automatic t_bad_period;
    restart_with(2'b00);
    pulses(16, 4);
    chk("R4 qualified before", ext_sel, 1'b1);
    pulses(11, 1);
    sync_in = 1'b1;
    wait_cyc(6);
    chk("R4 sync_ok after bad period", sync_ok, 1'b0);
    chk("R4 ext_sel after bad period", ext_sel, 1'b0);
    sync_in = 1'b0;
    wait_cyc(10);
  endtask

  task automatic t_timeout;
    restart_with(2'b00);
    pulses(16, 4);
    wait_cyc(24);
    chk("R5 still ok before timeout", sync_ok, 1'b1);
    wait_cyc(22);
    chk("R5 cleared after timeout", sync_ok, 1'b0);
  endtask

  task automatic t_restart;
    restart_with(2'b00);
    pulses(27, 4);
    chk("R6 ok on code 00", sync_ok, 1'b1);
    mult_sel = 2'b01;
    wait_cyc(2);
    chk("R6 code change clears", sync_ok, 1'b0);
    pulses(27, 4);
    chk("R6 requalified on code 01", sync_ok, 1'b1);
    sync_en = 1'b0;
    pulses(27, 4);
    chk("R6 disabled keeps sync_ok low", sync_ok, 1'b0);
    chk("R6 disabled keeps ext_sel low", ext_sel, 1'b0);
  endtask

  task automatic t_force;
    restart_with(2'b00);
    pulses(16, 4);
    mode_ctl = 2'b00;
    vsel_pin = 1'b0;
    pulses(16, 1);
    chk("R7 forced off ext_sel", ext_sel, 1'b0);
    chk("R7 forced off keeps status", sync_ok, 1'b1);
    vsel_pin = 1'b1;
    pulses(16, 1);
    chk("R7 vsel high releases", ext_sel, 1'b1);
    vsel_pin = 1'b0;
    mode_ctl = 2'b10;
    pulses(16, 1);
    chk("R7 other mode releases", ext_sel, 1'b1);
  endtask

  initial begin
    t_reset();
    t_window(2'b00, 12, 1'b1);
    t_window(2'b00, 11, 1'b0);
    t_window(2'b00, 27, 1'b1);
    t_window(2'b00, 28, 1'b0);
    t_window(2'b01, 24, 1'b1);
    t_window(2'b01, 23, 1'b0);
    t_window(2'b01, 54, 1'b1);
    t_window(2'b01, 55, 1'b0);
    t_window(2'b10, 36, 1'b1);
    t_window(2'b10, 35, 1'b0);
    t_window(2'b10, 80, 1'b1);
    t_window(2'b10, 81, 1'b0);
    t_window(2'b11, 48, 1'b1);
    t_window(2'b11, 47, 1'b0);
    t_window(2'b11, 107, 1'b1);
    t_window(2'b11, 108, 1'b0);
    t_qualify();
    t_bad_period();
    t_timeout();
    t_restart();
    t_force();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule